// File: doc/BRIEF.md
# Multiplexed Four-Digit Seven-Segment Driver

This block shows four BCD digits on four common-anode seven-segment digits while owning only one BCD-to-segment decoder. A select register steps through the digit positions each time a scan-rate strobe is seen. The same select value picks which BCD nibble reaches the decoder and which digit's anode is switched on. The two paths therefore cannot drift apart, and only one digit is lit at any instant.

All seven segment lines form one bus that every digit shares. The segment lines are active-low, so a driven-low line lights its bar on whichever anode is active. The anode enables are active-high. The segment bus and the anode enables are both taken from one output register. They change on the same clock edge, so a digit never shows the pattern that belongs to its neighbour. The parent logic supplies the strobe, which sets the refresh rate, and the four nibbles, which may change at any time.

Top module: `disp_scan_top`

## Requirements
- R1: At most one bit of `dig_en` is high in any cycle. `dig_en` is active-high, and exactly one bit is high in every cycle after the first clock edge following reset release.
- R2: `seg_n` is active-low, with bit 0 = segment a, bit 1 = b, bit 2 = c, bit 3 = d, bit 4 = e, bit 5 = f and bit 6 = g. It carries the decoded pattern of the digit whose enable is high in the same cycle.
- R3: The lit segments for codes 0..9 are: 0 abcdef, 1 bc, 2 abdeg, 3 abcdg, 4 bcfg, 5 acdfg, 6 acdefg, 7 abc, 8 all seven, 9 abcdfg. In particular, segment a is lit exactly when b3 | b1 | (b0 & b2) | (~b0 & ~b2).
- R4: Nibble values 10..15 on the selected digit blank the display: `seg_n` = 7'h7F.
- R5: Digit i takes its nibble from `bcd_digits[4i+3:4i]` and its anode from `dig_en[i]`. Each clock edge with `scan_en` high moves the select from i to i+1, and from 3 back to 0.
- R6: With `scan_en` low the select holds. A change on the selected digit's nibble still appears on `seg_n` one edge later.
- R7: While `rst` is high at an edge, the outputs become `seg_n` = 7'h7F and `dig_en` = 0, and the select becomes digit 0. The first edge after release lights digit 0, whatever `scan_en` is.
- R8: The outputs are registered. The values seen after an edge come from the select value and the nibbles present before that edge, and both output groups update together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scan_en | input | 1 | Scan-rate strobe that advances the digit select |
| bcd_digits | input | 16 | Four BCD nibbles, digit 0 in the low nibble |
| seg_n | output | 7 | Shared active-low segment bus, a in bit 0 |
| dig_en | output | 4 | Active-high anode enables, one per digit |

## Verification
A select register that skips a step, repeats or wraps at the wrong point shows up in `dig_en` at the next edge: the lit position no longer follows the strobe count. If the data multiplexer and the anode demultiplexer fell out of step, a digit would appear with its neighbour's pattern. That error shows on `seg_n` in the same cycle as the enable, so the bench sets a different nibble on every digit to make it visible at once. A wrong decoder entry or an unblanked invalid code shows on `seg_n` one edge after the nibble is selected.

// File: rtl/disp_scan_pkg.sv
package disp_scan_pkg;

    localparam int SEG_W = 7;
    localparam int BCD_W = 4;

    typedef logic [BCD_W-1:0] bcd_t;
    typedef logic [SEG_W-1:0] seg_t;

    // Segment bit positions on the shared bus.
    typedef enum int {
        SEG_A = 0, SEG_B = 1, SEG_C = 2, SEG_D = 3,
        SEG_E = 4, SEG_F = 5, SEG_G = 6
    } seg_pos_e;

    // Registered drive word presented at the block edge.
    typedef struct packed {
        seg_t seg_n;
    } seg_word_t;

    localparam seg_t SEG_BLANK_N = '1;

    // Active-high lit set for one decimal value; anything above 9 lights nothing.
    function automatic seg_t lit_segments(input bcd_t v);
        logic b0, b1, b2, b3;
        seg_t s;
        b0 = v[0];
        b1 = v[1];
        b2 = v[2];
        b3 = v[3];
        s = '0;
        if (v <= bcd_t'(9)) begin
            s[SEG_A] = b3 | b1 | (b0 & b2) | (~b0 & ~b2);
            s[SEG_B] = ~b2 | (b0 ~^ b1);
            s[SEG_C] = b2 | b0 | ~b1;
            s[SEG_D] = b3 | (~b0 & ~b2) | (b1 & ~b2) | (b1 & ~b0) | (b2 & ~b1 & b0);
            s[SEG_E] = ~b0 & (~b2 | b1);
            s[SEG_F] = b3 | (~b1 & ~b0) | (b2 & ~b1) | (b2 & ~b0);
            s[SEG_G] = b3 | (b2 & ~b1) | (~b2 & b1) | (b1 & ~b0);
        end
        return s;
    endfunction

    function automatic seg_word_t drive_word(input bcd_t v);
        seg_word_t w;
        w.seg_n = ~lit_segments(v);
        return w;
    endfunction

endpackage

// File: rtl/scan_select.sv
module scan_select #(
    parameter int NUM_DIGITS = 4,
    parameter int SEL_W      = $clog2(NUM_DIGITS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             advance,
    output logic [SEL_W-1:0] sel
);
    localparam logic [SEL_W-1:0] LAST = SEL_W'(NUM_DIGITS - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            sel <= '0;
        end else if (advance) begin
            sel <= (sel == LAST) ? '0 : sel + 1'b1;
        end
    end
endmodule

// File: rtl/digit_source_mux.sv
module digit_source_mux
    import disp_scan_pkg::*;
#(
    parameter int NUM_DIGITS = 4,
    parameter int SEL_W      = $clog2(NUM_DIGITS)
) (
    input  logic [NUM_DIGITS*BCD_W-1:0] bcd_bus,
    input  logic [SEL_W-1:0]            sel,
    output bcd_t                        picked
);
    bcd_t slot [NUM_DIGITS];

    for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_slot
        assign slot[i] = bcd_bus[i*BCD_W +: BCD_W];
    end

    always_comb begin
        picked = '0;
        for (int i = 0; i < NUM_DIGITS; i++) begin
            if (sel == SEL_W'(i)) picked = slot[i];
        end
    end
endmodule

// File: rtl/anode_demux.sv
module anode_demux #(
    parameter int NUM_DIGITS = 4,
    parameter int SEL_W      = $clog2(NUM_DIGITS)
) (
    input  logic [SEL_W-1:0]      sel,
    output logic [NUM_DIGITS-1:0] en
);
    for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_anode
        assign en[i] = (sel == SEL_W'(i));
    end
endmodule

// File: rtl/disp_scan_top.sv
module disp_scan_top
    import disp_scan_pkg::*;
#(
    parameter int NUM_DIGITS = 4,
    localparam int SEL_W     = $clog2(NUM_DIGITS),
    localparam int BUS_W     = NUM_DIGITS * BCD_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  scan_en,
    input  logic [BUS_W-1:0]      bcd_digits,
    output logic [SEG_W-1:0]      seg_n,
    output logic [NUM_DIGITS-1:0] dig_en
);
    logic [SEL_W-1:0]      sel_q;
    bcd_t                  cur_bcd;
    logic [NUM_DIGITS-1:0] en_comb;
    seg_word_t             word_q;
    logic [NUM_DIGITS-1:0] en_q;

    scan_select #(.NUM_DIGITS(NUM_DIGITS), .SEL_W(SEL_W)) u_sel (
        .clk     (clk),
        .rst     (rst),
        .advance (scan_en),
        .sel     (sel_q)
    );

    digit_source_mux #(.NUM_DIGITS(NUM_DIGITS), .SEL_W(SEL_W)) u_mux (
        .bcd_bus (bcd_digits),
        .sel     (sel_q),
        .picked  (cur_bcd)
    );

    anode_demux #(.NUM_DIGITS(NUM_DIGITS), .SEL_W(SEL_W)) u_demux (
        .sel (sel_q),
        .en  (en_comb)
    );

    // One register stage holds segments and anodes together.
    always_ff @(posedge clk) begin
        if (rst) begin
            word_q.seg_n <= SEG_BLANK_N;
            en_q         <= '0;
        end else begin
            word_q <= drive_word(cur_bcd);
            en_q   <= en_comb;
        end
    end

    assign seg_n  = word_q.seg_n;
    assign dig_en = en_q;
endmodule

// File: rtl/disp_scan_checker.sv
module disp_scan_checker
    import disp_scan_pkg::*;
#(
    parameter int NUM_DIGITS = 4,
    parameter int SEL_W      = $clog2(NUM_DIGITS)
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  scan_en,
    input logic [SEL_W-1:0]      sel,
    input bcd_t                  cur_bcd,
    input logic [SEG_W-1:0]      seg_n,
    input logic [NUM_DIGITS-1:0] dig_en
);
    localparam logic [SEL_W-1:0] LAST = SEL_W'(NUM_DIGITS - 1);

    logic seen_edge;
    always_ff @(posedge clk) begin
        seen_edge <= !rst;
    end

    assert_one_hot_max_R1: assert property (@(posedge clk) disable iff (rst)
        $onehot0(dig_en));

    assert_lit_after_start_R1: assert property (@(posedge clk) disable iff (rst)
        seen_edge |-> $onehot(dig_en));

    assert_anode_tracks_select_R8: assert property (@(posedge clk) disable iff (rst)
        seen_edge |-> dig_en == (NUM_DIGITS'(1) << $past(sel)));

    assert_step_wraps_R5: assert property (@(posedge clk) disable iff (rst)
        scan_en |=> sel == (($past(sel) == LAST) ? '0 : $past(sel) + 1'b1));

    assert_hold_when_idle_R6: assert property (@(posedge clk) disable iff (rst)
        !scan_en |=> $stable(sel));

    assert_invalid_blanks_R4: assert property (@(posedge clk) disable iff (rst)
        cur_bcd > bcd_t'(9) |=> seg_n == SEG_BLANK_N);

    assert_dark_is_blank_R7: assert property (@(posedge clk) disable iff (rst)
        dig_en == '0 |-> seg_n == SEG_BLANK_N);
endmodule

bind disp_scan_top disp_scan_checker #(.NUM_DIGITS(NUM_DIGITS)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .scan_en (scan_en),
    .sel     (sel_q),
    .cur_bcd (cur_bcd),
    .seg_n   (seg_n),
    .dig_en  (dig_en)
);

// File: tb/test_disp_scan_top.sv
module test_disp_scan_top;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        scan_en = 1'b0;
    logic [15:0] bcd_digits = 16'h0000;
    logic [6:0]  seg_n;
    logic [3:0]  dig_en;

    int vectors = 0;
    int misses  = 0;
    bit done    = 0;

    // Lit-segment sets from R3, written as {g,f,e,d,c,b,a}
    localparam logic [6:0] LIT [10] = '{
        7'b0111111, 7'b0000110, 7'b1011011, 7'b1001111, 7'b1100110,
        7'b1101101, 7'b1111101, 7'b0000111, 7'b1111111, 7'b1101111
    };

    int         sel_m = 0;
    logic [6:0] exp_seg;
    logic [3:0] exp_en;
    string      tag_seg;
    string      tag_en;

    disp_scan_top i_disp_scan_top (
        .clk        (clk),
        .rst        (rst),
        .scan_en    (scan_en),
        .bcd_digits (bcd_digits),
        .seg_n      (seg_n),
        .dig_en     (dig_en)
    );

    always #(PERIOD/2) clk = ~clk;

    task automatic cycle();
        int d;
        @(posedge clk);
        if (rst) begin
            exp_seg = 7'h7F; exp_en = 4'b0000; sel_m = 0;
            tag_seg = "R7"; tag_en = "R7";
        end else begin
            d = (bcd_digits >> (4*sel_m)) & 15;
            exp_seg = (d < 10) ? ~LIT[d] : 7'h7F;
            exp_en  = 4'(1 << sel_m);
            tag_seg = (d < 10) ? "R3/R2" : "R4";
            tag_en  = "R5/R1";
            if (scan_en) sel_m = (sel_m + 1) % 4;
        end
        @(negedge clk);
        vectors++;
        if (seg_n !== exp_seg) begin
            misses++;
            $display("FAIL %s seg_n actual=%b expected=%b t=%0t", tag_seg, seg_n, exp_seg, $time);
        end
        if (dig_en !== exp_en) begin
            misses++;
            $display("FAIL %s dig_en actual=%b expected=%b t=%0t", tag_en, dig_en, exp_en, $time);
        end
    endtask

    initial begin
        // R7: reset state, then digit 0 on first edge after release
        rst = 1'b1; scan_en = 1'b1; bcd_digits = 16'h4321;
        repeat (3) cycle();
        rst = 1'b0;
        cycle();
        // R5 and R8: scan through all digits, each with a distinct value
        for (int k = 0; k < 9; k++) cycle();
        // R3: walk every decimal value through every digit slot
        for (int v = 0; v < 10; v++) begin
            bcd_digits = {4'(v), 4'((v+3)%10), 4'((v+7)%10), 4'((v+1)%10)};
            for (int k = 0; k < 4; k++) cycle();
        end
        // R4: invalid codes 10..15 blank the bus
        for (int v = 10; v < 16; v++) begin
            bcd_digits = {4'(v), 4'd8, 4'(v), 4'd5};
            for (int k = 0; k < 4; k++) cycle();
        end
        // R6: hold the select, change the selected nibble
        scan_en = 1'b0;
        bcd_digits = 16'h9876;
        repeat (2) cycle();
        bcd_digits = 16'h1F02;
        repeat (2) cycle();
        bcd_digits = 16'h3579;
        cycle();
        // irregular strobe pattern
        for (int k = 0; k < 24; k++) begin
            scan_en = (k % 3 != 1);
            bcd_digits = 16'((k * 16'h1357) % 16'h9999);
            cycle();
        end
        // R7: reset in mid-scan returns to digit 0
        scan_en = 1'b1;
        rst = 1'b1;
        repeat (2) cycle();
        rst = 1'b0;
        scan_en = 1'b0;
        repeat (3) cycle();
        scan_en = 1'b1;
        repeat (6) cycle();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        #(PERIOD * 20000);
        if (!done) begin
            misses++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end
endmodule